// File: doc/BRIEF.md
# USB PHY Power-Up Sequencer

This block brings a combined USB 2 / USB 3 physical layer and its controller out of reset in one fixed order. A single start pulse launches the run. The block puts the PHY and the controller into reset and picks a reference clock from a status input. It then takes the PHY out of its low-leakage and test power-down states and reports power as stable. Next it performs one request/acknowledge handshake with the type-C configuration logic and turns on spread-spectrum clocking. It then releases the resets, with timed gaps between the releases, and finally forces the VBUS-valid indications on.

Each timed gap is a whole number of microseconds. The gaps are counted by a prescaler whose ratio is the number of system clocks per microsecond. A busy flag stays high while the run is in progress, and a done flag marks a finished run. If the handshake is not acknowledged in time, the run stops and an error flag is raised. A shutdown request puts the PHY back into reset and gates the pad reference clock from any state.

Top module: `usbphy_pwrseq`

## Requirements
- R1: After reset, every reset line (`phy_rst_n`, `usb2_por_n`, `ctl_aux_rst_n`, `ctl_core_rst_n`) is 0. `iddq` and `test_pd` are 1. `usb2_refsel` is 0. All other outputs are 0.
- R2: `start` is accepted only while the block is idle. The clock edge that samples it raises `busy` and drives `phy_rst_n` and `usb2_por_n` low. The same edge restores `iddq` and `test_pd` to 1 and every power, clock, spread-spectrum and VBUS output to 0. Both controller resets go low one cycle later.
- R3: Two cycles after `busy` rises, the clock choice is applied. If `clk_from_pad` is 0, `usb2_refsel` becomes 3 and `u3_pad_ref_en` and `pad_clk_en` stay 0. If it is 1, `usb2_refsel` becomes 2 and `u3_pad_ref_en` and `pad_clk_en` become 1. `usb2_refsel` never reads 1.
- R4: `iddq` falls one cycle after the clock choice. `test_pd` falls one cycle after `iddq`. One cycle later, `ana_pwr_en`, `pcs_pwr_stable`, `pma_pwr_stable` and `tc_req` all rise together.
- R5: `tc_req` stays high until `tc_ack` is sampled high. It falls on that edge. `ssc_en` rises one cycle later, and `phy_rst_n` and `usb2_por_n` rise one cycle after that.
- R6: If `tc_ack` is not seen within `TC_TIMEOUT` cycles of `tc_req` rising, then on that cycle `tc_req` falls, `err` rises and `busy` falls. The PHY stays in reset and `ssc_en` stays 0.
- R7: Both controller resets rise exactly `WAIT_US*CLK_PER_US` cycles after `phy_rst_n` rises.
- R8: `u3_vbus_ovr`, `u3_vbus_ovr_sel`, `u2_vbus_ovr` and `u2_vbus_ovr_sel` rise together, exactly `WAIT_US*CLK_PER_US` cycles after the controller resets rise.
- R9: `done` rises and `busy` falls exactly `WAIT_US*CLK_PER_US` cycles after the VBUS overrides rise. `done` and `busy` are never high together.
- R10: A `start` pulse while `busy` is high has no effect. The run's timing is unchanged and it completes once.
- R11: The clock edge that samples `shutdown` drives `phy_rst_n`, `usb2_por_n`, `pad_clk_en`, `tc_req`, `busy` and `done` to 0 and returns the block to idle. All other outputs hold. `shutdown` wins over a simultaneous `start`, and a run stopped by `shutdown` never reports `done`.
- R12: After `done` or `err`, a new `start` clears `done` and `err` and runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the bring-up sequence |
| shutdown | input | 1 | Return the PHY to reset and gate the pad clock |
| clk_from_pad | input | 1 | Clock status: 1 selects the pad reference clock |
| tc_ack | input | 1 | Type-C configuration acknowledge |
| phy_rst_n | output | 1 | USB 3 PHY reset, active low |
| usb2_por_n | output | 1 | USB 2 PHY power-on reset, active low |
| ctl_aux_rst_n | output | 1 | Controller auxiliary reset, active low |
| ctl_core_rst_n | output | 1 | Controller core reset, active low |
| iddq | output | 1 | USB 2 PHY low-leakage mode |
| test_pd | output | 1 | USB 3 PHY test power-down |
| ana_pwr_en | output | 1 | Analog power enable |
| pcs_pwr_stable | output | 1 | PCS power-stable indication |
| pma_pwr_stable | output | 1 | PMA power-stable indication |
| usb2_refsel | output | 2 | USB 2 reference select (3 internal, 2 pad) |
| u3_pad_ref_en | output | 1 | USB 3 PHY uses the pad reference |
| pad_clk_en | output | 1 | Pad reference clock gate enable |
| tc_req | output | 1 | Type-C configuration request |
| ssc_en | output | 1 | Spread-spectrum enable |
| u3_vbus_ovr | output | 1 | USB 3 forced VBUS-valid value |
| u3_vbus_ovr_sel | output | 1 | USB 3 VBUS-valid override select |
| u2_vbus_ovr | output | 1 | USB 2 forced external VBUS-valid value |
| u2_vbus_ovr_sel | output | 1 | USB 2 VBUS-valid override select |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished |
| err | output | 1 | Handshake timed out |

## Verification
The bench timestamps every output transition and compares the gaps with the cycle counts in the requirements. A timer that does not restart cleanly between back-to-back waits would make the second or third gap off by one. A wrong prescaler would scale all three gaps.

Runs that end with no acknowledge check the exact timeout window. A design that counts one cycle too many or too few, or that still releases the PHY after a timeout, is reported.

Further cases cover:
- a start pulse that arrives mid-run (a design that restarts would stretch the sequence);
- shutdown during a wait and shutdown together with start (a design that still finishes would raise `done`);
- restarts after done and after error, where outputs left over from the last run must be cleared before the controller resets fall.

// File: rtl/usbpwr_pkg.sv
package usbpwr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CTL_RST, S_CLK, S_IDDQ, S_TPD, S_PWR, S_TC,
    S_SSC, S_PREL, S_W_CTL, S_W_VBUS, S_W_DONE
  } seq_state_t;

  localparam logic [1:0] REFSEL_RST = 2'd0;
  localparam logic [1:0] REFSEL_PAD = 2'd2;
  localparam logic [1:0] REFSEL_INT = 2'd3;
endpackage

// File: rtl/usbpwr_us_timer.sv
module usbpwr_us_timer #(
  parameter int CLK_PER_US = 200,
  parameter int WAIT_US    = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = (WAIT_US > 1) ? $clog2(WAIT_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_LAST  = UW'(WAIT_US - 1);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          tick;

  assign tick   = run && (pre_q == PRE_LAST);
  assign expire = tick && (us_q == US_LAST);

  // Free-running while run is high; it wraps at expiry so back-to-back waits stay exact.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      us_q  <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) us_q <= (us_q == US_LAST) ? '0 : us_q + 1'b1;
    end
  end

  p_us_range_r7: assert property (@(posedge clk) disable iff (rst)
    us_q <= US_LAST);
endmodule

// File: rtl/usbpwr_hs_timeout.sv
module usbpwr_hs_timeout #(
  parameter int TIMEOUT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic ack,
  output logic timeout
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign timeout = en && !ack && (cnt_q == LAST);
endmodule

// File: rtl/usbphy_pwrseq.sv
module usbphy_pwrseq
  import usbpwr_pkg::*;
#(
  parameter int CLK_PER_US = 200,
  parameter int WAIT_US    = 100,
  parameter int TC_TIMEOUT = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       shutdown,
  input  logic       clk_from_pad,
  input  logic       tc_ack,
  output logic       phy_rst_n,
  output logic       usb2_por_n,
  output logic       ctl_aux_rst_n,
  output logic       ctl_core_rst_n,
  output logic       iddq,
  output logic       test_pd,
  output logic       ana_pwr_en,
  output logic       pcs_pwr_stable,
  output logic       pma_pwr_stable,
  output logic [1:0] usb2_refsel,
  output logic       u3_pad_ref_en,
  output logic       pad_clk_en,
  output logic       tc_req,
  output logic       ssc_en,
  output logic       u3_vbus_ovr,
  output logic       u3_vbus_ovr_sel,
  output logic       u2_vbus_ovr,
  output logic       u2_vbus_ovr_sel,
  output logic       busy,
  output logic       done,
  output logic       err
);
  seq_state_t state_q;
  logic       dly_run, dly_exp, hs_tmo;

  assign dly_run = (state_q == S_W_CTL) || (state_q == S_W_VBUS) || (state_q == S_W_DONE);

  usbpwr_us_timer #(.CLK_PER_US(CLK_PER_US), .WAIT_US(WAIT_US)) u_timer (
    .clk(clk), .rst(rst), .run(dly_run), .expire(dly_exp));

  usbpwr_hs_timeout #(.TIMEOUT(TC_TIMEOUT)) u_hs (
    .clk(clk), .rst(rst), .en(state_q == S_TC), .ack(tc_ack), .timeout(hs_tmo));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      phy_rst_n <= 1'b0; usb2_por_n <= 1'b0;
      ctl_aux_rst_n <= 1'b0; ctl_core_rst_n <= 1'b0;
      iddq <= 1'b1; test_pd <= 1'b1;
      ana_pwr_en <= 1'b0; pcs_pwr_stable <= 1'b0; pma_pwr_stable <= 1'b0;
      usb2_refsel <= REFSEL_RST; u3_pad_ref_en <= 1'b0; pad_clk_en <= 1'b0;
      tc_req <= 1'b0; ssc_en <= 1'b0;
      u3_vbus_ovr <= 1'b0; u3_vbus_ovr_sel <= 1'b0;
      u2_vbus_ovr <= 1'b0; u2_vbus_ovr_sel <= 1'b0;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else if (shutdown) begin
      state_q <= S_IDLE;
      phy_rst_n <= 1'b0; usb2_por_n <= 1'b0; pad_clk_en <= 1'b0;
      tc_req <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          busy <= 1'b1; done <= 1'b0; err <= 1'b0;
          phy_rst_n <= 1'b0; usb2_por_n <= 1'b0;
          iddq <= 1'b1; test_pd <= 1'b1;
          ana_pwr_en <= 1'b0; pcs_pwr_stable <= 1'b0; pma_pwr_stable <= 1'b0;
          usb2_refsel <= REFSEL_RST; u3_pad_ref_en <= 1'b0; pad_clk_en <= 1'b0;
          ssc_en <= 1'b0;
          u3_vbus_ovr <= 1'b0; u3_vbus_ovr_sel <= 1'b0;
          u2_vbus_ovr <= 1'b0; u2_vbus_ovr_sel <= 1'b0;
          state_q <= S_CTL_RST;
        end
        S_CTL_RST: begin
          ctl_aux_rst_n <= 1'b0; ctl_core_rst_n <= 1'b0;
          state_q <= S_CLK;
        end
        S_CLK: begin
          usb2_refsel   <= clk_from_pad ? REFSEL_PAD : REFSEL_INT;
          u3_pad_ref_en <= clk_from_pad;
          pad_clk_en    <= clk_from_pad;
          state_q <= S_IDDQ;
        end
        S_IDDQ: begin iddq <= 1'b0; state_q <= S_TPD; end
        S_TPD:  begin test_pd <= 1'b0; state_q <= S_PWR; end
        S_PWR: begin
          ana_pwr_en <= 1'b1; pcs_pwr_stable <= 1'b1; pma_pwr_stable <= 1'b1;
          tc_req <= 1'b1;
          state_q <= S_TC;
        end
        S_TC: if (tc_ack) begin
          tc_req <= 1'b0; state_q <= S_SSC;
        end else if (hs_tmo) begin
          tc_req <= 1'b0; err <= 1'b1; busy <= 1'b0; state_q <= S_IDLE;
        end
        S_SSC:  begin ssc_en <= 1'b1; state_q <= S_PREL; end
        S_PREL: begin
          phy_rst_n <= 1'b1; usb2_por_n <= 1'b1; state_q <= S_W_CTL;
        end
        S_W_CTL: if (dly_exp) begin
          ctl_aux_rst_n <= 1'b1; ctl_core_rst_n <= 1'b1; state_q <= S_W_VBUS;
        end
        S_W_VBUS: if (dly_exp) begin
          u3_vbus_ovr <= 1'b1; u3_vbus_ovr_sel <= 1'b1;
          u2_vbus_ovr <= 1'b1; u2_vbus_ovr_sel <= 1'b1;
          state_q <= S_W_DONE;
        end
        S_W_DONE: if (dly_exp) begin
          done <= 1'b1; busy <= 1'b0; state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_refsel_code_r3: assert property (@(posedge clk) disable iff (rst)
    usb2_refsel != 2'd1);
  p_phy_rel_ready_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_rst_n) |-> ssc_en && !iddq && !test_pd && pma_pwr_stable && !tc_req);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    tc_req && !tc_ack && !hs_tmo && !shutdown |=> tc_req);
  p_err_idle_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !busy && !phy_rst_n && !ssc_en);
  p_ctl_after_phy_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_core_rst_n) |-> phy_rst_n && usb2_por_n && ctl_aux_rst_n);
  p_vbus_after_ctl_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(u3_vbus_ovr) |-> ctl_aux_rst_n && ctl_core_rst_n && u2_vbus_ovr_sel);
  p_done_busy_r9: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));
  p_shutdown_r11: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> !phy_rst_n && !usb2_por_n && !pad_clk_en && !busy && !done);
endmodule

// File: tb/usbphy_pwrseq_tb.sv
`timescale 1ns/1ps
module usbphy_pwrseq_tb;
  localparam int CPU = 2;
  localparam int WUS = 100;
  localparam int TO  = 16;
  localparam int N   = CPU * WUS;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, shutdown = 1'b0, clk_from_pad = 1'b0, tc_ack = 1'b0;
  logic phy_rst_n, usb2_por_n, ctl_aux_rst_n, ctl_core_rst_n, iddq, test_pd;
  logic ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, u3_pad_ref_en, pad_clk_en;
  logic tc_req, ssc_en, u3_vbus_ovr, u3_vbus_ovr_sel, u2_vbus_ovr, u2_vbus_ovr_sel;
  logic busy, done, err;
  logic [1:0] usb2_refsel;

  int total = 0, bad = 0, cyc = 0;
  int t_busy, t_clk, t_iddq, t_tpd, t_pwr, t_treq, t_tfall, t_ssc, t_phy, t_ctl, t_vbus, t_done, t_err;
  int n_done;
  logic p_busy, p_iddq, p_tpd, p_pma, p_treq, p_ssc, p_phy, p_ctl, p_vbus, p_done, p_err;
  logic [1:0] p_ref;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  usbphy_pwrseq #(.CLK_PER_US(CPU), .WAIT_US(WUS), .TC_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .start(start), .shutdown(shutdown), .clk_from_pad(clk_from_pad),
    .tc_ack(tc_ack), .phy_rst_n(phy_rst_n), .usb2_por_n(usb2_por_n),
    .ctl_aux_rst_n(ctl_aux_rst_n), .ctl_core_rst_n(ctl_core_rst_n), .iddq(iddq),
    .test_pd(test_pd), .ana_pwr_en(ana_pwr_en), .pcs_pwr_stable(pcs_pwr_stable),
    .pma_pwr_stable(pma_pwr_stable), .usb2_refsel(usb2_refsel), .u3_pad_ref_en(u3_pad_ref_en),
    .pad_clk_en(pad_clk_en), .tc_req(tc_req), .ssc_en(ssc_en), .u3_vbus_ovr(u3_vbus_ovr),
    .u3_vbus_ovr_sel(u3_vbus_ovr_sel), .u2_vbus_ovr(u2_vbus_ovr), .u2_vbus_ovr_sel(u2_vbus_ovr_sel),
    .busy(busy), .done(done), .err(err));

  function automatic int exp_refsel(input bit pad);
    return pad ? 2 : 3;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic arm();
    t_busy = -1; t_clk = -1; t_iddq = -1; t_tpd = -1; t_pwr = -1; t_treq = -1; t_tfall = -1;
    t_ssc = -1; t_phy = -1; t_ctl = -1; t_vbus = -1; t_done = -1; t_err = -1; n_done = 0;
  endtask

  // Timestamps the first transition of each output after arm().
  always @(negedge clk) begin
    if (!rst) begin
      if (busy && !p_busy && t_busy < 0) t_busy = cyc;
      if (usb2_refsel != 0 && p_ref == 0 && t_clk < 0) t_clk = cyc;
      if (!iddq && p_iddq && t_iddq < 0) t_iddq = cyc;
      if (!test_pd && p_tpd && t_tpd < 0) t_tpd = cyc;
      if (pma_pwr_stable && !p_pma && t_pwr < 0) t_pwr = cyc;
      if (tc_req && !p_treq && t_treq < 0) t_treq = cyc;
      if (!tc_req && p_treq && t_tfall < 0) t_tfall = cyc;
      if (ssc_en && !p_ssc && t_ssc < 0) t_ssc = cyc;
      if (phy_rst_n && !p_phy && t_phy < 0) t_phy = cyc;
      if (ctl_core_rst_n && !p_ctl && t_ctl < 0) t_ctl = cyc;
      if (u3_vbus_ovr && !p_vbus && t_vbus < 0) t_vbus = cyc;
      if (done && !p_done) begin n_done++; if (t_done < 0) t_done = cyc; end
      if (err && !p_err && t_err < 0) t_err = cyc;
    end
    p_busy = busy; p_ref = usb2_refsel; p_iddq = iddq; p_tpd = test_pd; p_pma = pma_pwr_stable;
    p_treq = tc_req; p_ssc = ssc_en; p_phy = phy_rst_n; p_ctl = ctl_core_rst_n;
    p_vbus = u3_vbus_ovr; p_done = done; p_err = err;
  end

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic do_run(input bit pad, input int d, input bit give_ack, input bit poke);
    bit poked = 0;
    clk_from_pad = pad;
    arm();
    pulse_start();
    while (!tc_req) @(negedge clk);
    if (give_ack) begin
      repeat (d) @(negedge clk);
      tc_ack = 1'b1;
      @(negedge clk);
      while (tc_req) @(negedge clk);
      tc_ack = 1'b0;
    end
    while (!done && !err) begin
      @(negedge clk);
      if (poke && !poked && t_ctl >= 0) begin pulse_start(); poked = 1; end
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic check_good_run(input bit pad, input int d);
    chk("R3 clock choice cycle", t_clk - t_busy, 2);
    chk("R3 refsel", usb2_refsel, exp_refsel(pad));
    chk("R3 pad ref", u3_pad_ref_en, pad);
    chk("R3 pad clk", pad_clk_en, pad);
    chk("R4 iddq", t_iddq - t_clk, 1);
    chk("R4 test_pd", t_tpd - t_iddq, 1);
    chk("R4 power stable", t_pwr - t_tpd, 1);
    chk("R4 tc_req with power", t_treq, t_pwr);
    chk("R4 ana/pcs", {ana_pwr_en, pcs_pwr_stable}, 3);
    chk("R5 req held until ack", t_tfall - t_treq, d + 1);
    chk("R5 ssc", t_ssc - t_tfall, 1);
    chk("R5 phy release", t_phy - t_ssc, 1);
    chk("R5 por", usb2_por_n, 1);
    chk("R7 ctl gap", t_ctl - t_phy, N);
    chk("R7 aux", ctl_aux_rst_n, 1);
    chk("R8 vbus gap", t_vbus - t_ctl, N);
    chk("R8 vbus set", {u3_vbus_ovr, u3_vbus_ovr_sel, u2_vbus_ovr, u2_vbus_ovr_sel}, 15);
    chk("R9 done gap", t_done - t_vbus, N);
    chk("R9 busy low", busy, 0);
    chk("R9 done once", n_done, 1);
    chk("R12 err clear", err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    arm();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 resets", {phy_rst_n, usb2_por_n, ctl_aux_rst_n, ctl_core_rst_n}, 0);
    chk("R1 iddq/test_pd", {iddq, test_pd}, 3);
    chk("R1 refsel", usb2_refsel, 0);
    chk("R1 flags", {busy, done, err, tc_req, ssc_en, u3_vbus_ovr, pad_clk_en}, 0);

    // Directed: internal clock
    do_run(1'b0, 3, 1'b1, 1'b0);
    check_good_run(1'b0, 3);

    // R2/R12: restart after done, pad clock, mid-run start poke (R10)
    clk_from_pad = 1'b1;
    arm();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 phy reset first", {phy_rst_n, usb2_por_n}, 0);
    chk("R2 ctl still out", ctl_core_rst_n, 1);
    chk("R2 busy", busy, 1);
    chk("R12 done cleared", done, 0);
    chk("R2 defaults restored", {iddq, test_pd, u3_vbus_ovr, ssc_en, pma_pwr_stable}, 5'b11000);
    @(negedge clk);
    chk("R2 ctl reset next", {ctl_aux_rst_n, ctl_core_rst_n}, 0);
    while (!tc_req) @(negedge clk);
    tc_ack = 1'b1;
    @(negedge clk);
    tc_ack = 1'b0;
    while (t_ctl < 0) @(negedge clk);
    repeat (5) @(negedge clk);
    pulse_start();  // R10: ignored while busy
    while (!done) @(negedge clk);
    repeat (4) @(negedge clk);
    check_good_run(1'b1, 0);
    chk("R10 busy poke no effect", t_done - t_phy, 3 * N);

    // R11: shutdown after done with pad clock
    @(negedge clk) shutdown = 1'b1;
    @(negedge clk) shutdown = 1'b0;
    chk("R11 phy/por low", {phy_rst_n, usb2_por_n}, 0);
    chk("R11 pad clk gated", pad_clk_en, 0);
    chk("R11 done/busy", {done, busy}, 0);
    chk("R11 held ctl", {ctl_aux_rst_n, ctl_core_rst_n}, 3);
    chk("R11 held vbus/refsel", {u3_vbus_ovr, u2_vbus_ovr_sel, usb2_refsel}, 4'b1110);

    // R6: timeout
    do_run(1'b0, 0, 1'b0, 1'b0);
    chk("R6 timeout window", t_err - t_treq, TO);
    chk("R6 flags", {err, busy, tc_req}, 3'b100);
    chk("R6 phy held", {phy_rst_n, ssc_en}, 0);
    chk("R6 no done", n_done, 0);

    // R12 + random runs
    for (int i = 0; i < 6; i++) begin
      bit pad;
      int d;
      pad = 1'($urandom_range(0, 1));
      d = int'($urandom_range(0, TO - 2));
      do_run(pad, d, 1'b1, 1'b0);
      check_good_run(pad, d);
    end

    // R11: shutdown during a wait, then no done
    clk_from_pad = 1'b1;
    arm();
    pulse_start();
    while (!tc_req) @(negedge clk);
    tc_ack = 1'b1;
    @(negedge clk);
    tc_ack = 1'b0;
    while (t_ctl < 0) @(negedge clk);
    repeat (7) @(negedge clk);
    shutdown = 1'b1;
    @(negedge clk) shutdown = 1'b0;
    chk("R11 mid-run busy", busy, 0);
    chk("R11 mid-run phy", phy_rst_n, 0);
    chk("R11 mid-run pad gate", pad_clk_en, 0);
    repeat (3 * N) @(negedge clk);
    chk("R11 stopped run no done", n_done, 0);
    chk("R11 vbus untouched", u3_vbus_ovr, 0);

    // R11: shutdown beats start
    @(negedge clk) begin start = 1'b1; shutdown = 1'b1; end
    @(negedge clk) begin start = 1'b0; shutdown = 1'b0; end
    chk("R11 shutdown priority", busy, 0);
    repeat (4) @(negedge clk);
    chk("R11 still idle", {busy, tc_req}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule